// File: doc/BRIEF.md
# Chip-8 Move and Dispatch Unit

This block carries out the plain data-move opcodes of a Chip-8 machine and makes the first dispatch decision for the rest. A fetched 16-bit instruction is presented as a high byte and a low byte together with a one-cycle `start`. The unit latches the opcode and tells the fetch logic that the program counter may step past the two-byte instruction. It then waits out a fixed latency that depends on the opcode, and closes with a one-cycle `done`. Writes, hand-offs and the index update all happen in that closing cycle, or on the edge that opens it.

Three opcode families are executed here. `6XNN` loads an immediate byte into variable VX. `8XY0` copies VY into VX, reading VY from an external sixteen-entry variable file through a read address. `ANNN` loads the 12-bit index register I. A `8XYN` opcode with a nonzero N is passed to an external arithmetic/logic unit on a strobe that carries X, Y and N. An `FXNN` opcode raises a second-stage dispatch strobe whose selector is the whole low byte. Every other top nibble only completes with `done`.

The controller has three named states. `S_IDLE` waits for `start`. On `start` the opcode is latched and the counter is loaded (transition ACCEPT). `S_WAIT` counts down and moves to `S_FINISH` when the counter reaches zero (transition EXPIRE). `S_FINISH` drives `done` and the outputs for the opcode, then returns to `S_IDLE` (transition RETIRE).

Top module: `c8mv_unit`

## Requirements
- R1: After reset, `done`, `pc_adv`, `v_we`, `alu_req` and `fx_req` are low and `idx` is 0x000.
- R2: `done` goes high for exactly one cycle, L rising edges after the edge that samples `start`. L is 6 for top nibble 0x6, 12 for 0x8 with low nibble 0, 8 for 0x8 with a nonzero low nibble, 12 for 0xA, 4 for 0xF, and 2 for any other top nibble.
- R3: For top nibble 0x6, `v_we` is high in the `done` cycle with `v_waddr` equal to instruction bits 11:8 and `v_wdata` equal to the low byte.
- R4: For top nibble 0x8 with low nibble 0, `v_raddr` is instruction bits 7:4 while the unit is busy. In the `done` cycle, `v_we` is high with `v_waddr` equal to bits 11:8 and `v_wdata` equal to `v_rdata`.
- R5: For top nibble 0x8 with a nonzero low nibble, `alu_req` is high in the `done` cycle with `alu_x` equal to bits 11:8, `alu_y` equal to bits 7:4 and `alu_fn` equal to bits 3:0. No variable write occurs.
- R6: For top nibble 0xA, `idx` takes the value of instruction bits 11:0, with the top nibble dropped, on the edge that raises `done`. It holds its value at all other times. No variable write occurs.
- R7: For top nibble 0xF, `fx_req` is high in the `done` cycle with `fx_sel` equal to the low byte. No variable write occurs.
- R8: Any other top nibble causes no write, no strobe and no change to `idx`.
- R9: `pc_adv` is high for exactly the one cycle after the edge that samples `start`.
- R10: `start` is ignored while an instruction is in progress. The opcode inputs may change after `start` without affecting the result.
- R11: `v_we`, `alu_req` and `fx_req` are high only in a `done` cycle, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled in S_IDLE only) |
| op_hi | input | 8 | Instruction high byte |
| op_lo | input | 8 | Instruction low byte |
| v_rdata | input | 8 | VY value from the variable file |
| v_raddr | output | 4 | Variable file read address (Y field) |
| v_we | output | 1 | Variable file write enable |
| v_waddr | output | 4 | Variable file write address (X field) |
| v_wdata | output | 8 | Variable file write data |
| idx | output | 12 | Index register I |
| pc_adv | output | 1 | Program counter step strobe |
| alu_req | output | 1 | Arithmetic/logic hand-off strobe |
| alu_x | output | 4 | X field for the hand-off |
| alu_y | output | 4 | Y field for the hand-off |
| alu_fn | output | 4 | Function nibble for the hand-off |
| fx_req | output | 1 | Second-stage dispatch strobe |
| fx_sel | output | 8 | Second-stage handler selector |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed opcodes cover each top nibble with corner fields: X and Y at 0 and 15, `AD08` and `AFFF` for index masking, and 8XY0 against every nonzero function nibble. These separate the latencies and the write, hand-off and dispatch paths. Random opcodes with fixed seeds mix all sixteen top nibbles, including the ones that do nothing, and exercise the decode as a whole. In some runs `start` is pulsed again mid-instruction while the opcode inputs are scrambled. This separates a unit that latches the opcode and ignores a busy `start` from one that restarts or decodes live inputs.

// File: rtl/c8mv_pkg.sv
package c8mv_pkg;
    typedef enum logic [2:0] {
        K_SETV,
        K_COPY,
        K_ARITH,
        K_SETIDX,
        K_MISC,
        K_NONE
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_FINISH
    } st_e;

    localparam int IDX_W = 12;
    localparam int FLD_W = 4;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/c8mv_classify.sv
module c8mv_classify
    import c8mv_pkg::*;
#(
    parameter int LAT_SETV  = 6,
    parameter int LAT_COPY  = 12,
    parameter int LAT_ARITH = 8,
    parameter int LAT_IDX   = 12,
    parameter int LAT_MISC  = 4,
    parameter int LAT_NONE  = 2,
    parameter int CW        = 4
) (
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    output op_kind_e          kind,
    output logic [CW-1:0]     lat_m1
);
    always_comb begin
        kind   = K_NONE;
        lat_m1 = CW'(LAT_NONE - 1);
        unique case (hi[7:4])
            4'h6: begin
                kind   = K_SETV;
                lat_m1 = CW'(LAT_SETV - 1);
            end
            4'h8: begin
                if (lo[3:0] == 4'h0) begin
                    kind   = K_COPY;
                    lat_m1 = CW'(LAT_COPY - 1);
                end else begin
                    kind   = K_ARITH;
                    lat_m1 = CW'(LAT_ARITH - 1);
                end
            end
            4'hA: begin
                kind   = K_SETIDX;
                lat_m1 = CW'(LAT_IDX - 1);
            end
            4'hF: begin
                kind   = K_MISC;
                lat_m1 = CW'(LAT_MISC - 1);
            end
            default: begin
                kind   = K_NONE;
                lat_m1 = CW'(LAT_NONE - 1);
            end
        endcase
    end
endmodule

// File: rtl/c8mv_timer.sv
module c8mv_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    p_cnt_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/c8mv_index.sv
module c8mv_index
    import c8mv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] d,
    output logic [IDX_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/c8mv_unit.sv
module c8mv_unit
    import c8mv_pkg::*;
#(
    parameter int LAT_SETV  = 6,
    parameter int LAT_COPY  = 12,
    parameter int LAT_ARITH = 8,
    parameter int LAT_IDX   = 12,
    parameter int LAT_MISC  = 4,
    parameter int LAT_NONE  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       op_hi,
    input  logic [7:0]       op_lo,
    input  logic [7:0]       v_rdata,
    output logic [3:0]       v_raddr,
    output logic             v_we,
    output logic [3:0]       v_waddr,
    output logic [7:0]       v_wdata,
    output logic [11:0]      idx,
    output logic             pc_adv,
    output logic             alu_req,
    output logic [3:0]       alu_x,
    output logic [3:0]       alu_y,
    output logic [3:0]       alu_fn,
    output logic             fx_req,
    output logic [7:0]       fx_sel,
    output logic             done
);
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int LAT_MAX = max_of(max_of(max_of(LAT_SETV, LAT_COPY), max_of(LAT_ARITH, LAT_IDX)),
                                     max_of(LAT_MISC, LAT_NONE));
    localparam int CW = (LAT_MAX < 2) ? 1 : $clog2(LAT_MAX);

    st_e               state_q, state_d;
    op_kind_e          kind_q, kind_d;
    logic [CW-1:0]     lat_m1;
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic              pc_adv_q;
    logic              accept, tmr_zero, idx_we, fin;

    c8mv_classify #(
        .LAT_SETV (LAT_SETV),
        .LAT_COPY (LAT_COPY),
        .LAT_ARITH(LAT_ARITH),
        .LAT_IDX  (LAT_IDX),
        .LAT_MISC (LAT_MISC),
        .LAT_NONE (LAT_NONE),
        .CW       (CW)
    ) u_classify (
        .hi    (op_hi),
        .lo    (op_lo),
        .kind  (kind_d),
        .lat_m1(lat_m1)
    );

    c8mv_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(lat_m1),
        .run     (state_q == S_WAIT),
        .zero    (tmr_zero)
    );

    // Next-state logic: ACCEPT, EXPIRE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_WAIT;
            S_WAIT:   if (tmr_zero) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign accept = (state_q == S_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= K_NONE;
            hi_q     <= '0;
            lo_q     <= '0;
            pc_adv_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            pc_adv_q <= accept;
            if (accept) begin
                kind_q <= kind_d;
                hi_q   <= op_hi;
                lo_q   <= op_lo;
            end
        end
    end

    assign idx_we = (state_q == S_WAIT) && tmr_zero && (kind_q == K_SETIDX);

    c8mv_index u_index (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (idx_we),
        .d    ({hi_q[3:0], lo_q}),
        .q    (idx)
    );

    // Output process
    always_comb begin
        fin     = (state_q == S_FINISH);
        done    = fin;
        pc_adv  = pc_adv_q;
        v_raddr = lo_q[7:4];
        v_waddr = hi_q[3:0];
        v_we    = 1'b0;
        v_wdata = lo_q;
        alu_req = 1'b0;
        fx_req  = 1'b0;
        alu_x   = hi_q[3:0];
        alu_y   = lo_q[7:4];
        alu_fn  = lo_q[3:0];
        fx_sel  = lo_q;
        unique case (kind_q)
            K_SETV:   v_we = fin;
            K_COPY: begin
                v_we    = fin;
                v_wdata = v_rdata;
            end
            K_ARITH:  alu_req = fin;
            K_MISC:   fx_req = fin;
            K_SETIDX: ;
            default:  ;
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!done && !v_we && !alu_req && !fx_req));
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_pcadv_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pc_adv && !done));
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && start) |=> (state_q != S_IDLE));
    p_strobe_in_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (v_we || alu_req || fx_req) |-> done);
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v_we, alu_req, fx_req}));
    p_idx_moves_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx) |-> done);
endmodule

// File: tb/c8mv_unit_bench.sv
module c8mv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_hi = 8'h00, op_lo = 8'h00;
    logic [7:0]  v_rdata;
    logic [3:0]  v_raddr, v_waddr, alu_x, alu_y, alu_fn;
    logic        v_we, pc_adv, alu_req, fx_req, done;
    logic [7:0]  v_wdata, fx_sel;
    logic [11:0] idx;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [11:0] idx_model = 12'h000;

    always #10 clk = ~clk;

    function automatic logic [7:0] vfile(input logic [3:0] a);
        return ({4'h0, a} * 8'h1D) ^ 8'h5A;
    endfunction

    assign v_rdata = vfile(v_raddr);

    c8mv_unit u_c8mv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_hi(op_hi), .op_lo(op_lo),
        .v_rdata(v_rdata), .v_raddr(v_raddr), .v_we(v_we), .v_waddr(v_waddr),
        .v_wdata(v_wdata), .idx(idx), .pc_adv(pc_adv), .alu_req(alu_req),
        .alu_x(alu_x), .alu_y(alu_y), .alu_fn(alu_fn), .fx_req(fx_req),
        .fx_sel(fx_sel), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [7:0] hi, input logic [7:0] lo);
        case (hi[7:4])
            4'h6: return 6;
            4'h8: return (lo[3:0] == 4'h0) ? 12 : 8;
            4'hA: return 12;
            4'hF: return 4;
            default: return 2;
        endcase
    endfunction

    task automatic run_op(input logic [7:0] hi, input logic [7:0] lo, input bit interfere);
        int j_done = -1;
        bit pc_ok = 1;
        bit quiet_ok = 1;
        bit raddr_ok = 1;
        bit idx_ok = 1;
        int lat = exp_lat(hi, lo);
        @(negedge clk);
        op_hi = hi; op_lo = lo; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_hi = ~hi; op_lo = ~lo;
        for (int j = 1; j <= 20; j++) begin
            if (j > 1) @(negedge clk);
            if (pc_adv != (j == 1)) pc_ok = 0;
            if (interfere && j == 2) begin
                start = 1'b1; op_hi = 8'h6E; op_lo = 8'h77;
            end
            if (interfere && j == 3) start = 1'b0;
            if (done) begin
                j_done = j;
                break;
            end
            if (v_we || alu_req || fx_req) quiet_ok = 0;
            if (idx != idx_model) idx_ok = 0;
            if (hi[7:4] == 4'h8 && lo[3:0] == 4'h0 && v_raddr != lo[7:4]) raddr_ok = 0;
        end
        chk(j_done - 1 == lat, "R2 latency", j_done - 1, lat);
        chk(pc_ok, "R9 pc_adv pulse", pc_ok, 1);
        chk(quiet_ok, "R11 strobe outside done", quiet_ok, 1);
        chk(idx_ok, "R6 idx before done", idx, idx_model);
        case (hi[7:4])
            4'h6: begin
                chk(v_we && v_waddr == hi[3:0] && v_wdata == lo, "R3 load immediate",
                    {v_we, v_waddr, v_wdata}, {1'b1, hi[3:0], lo});
            end
            4'h8: begin
                if (lo[3:0] == 4'h0) begin
                    chk(raddr_ok, "R4 read address", v_raddr, lo[7:4]);
                    chk(v_we && v_waddr == hi[3:0] && v_wdata == vfile(lo[7:4]), "R4 copy",
                        {v_we, v_waddr, v_wdata}, {1'b1, hi[3:0], vfile(lo[7:4])});
                end else begin
                    chk(alu_req && !v_we && alu_x == hi[3:0] && alu_y == lo[7:4] && alu_fn == lo[3:0],
                        "R5 alu hand-off", {alu_req, v_we, alu_x, alu_y, alu_fn},
                        {2'b10, hi[3:0], lo});
                end
            end
            4'hA: begin
                idx_model = {hi[3:0], lo};
                chk(idx == idx_model && !v_we, "R6 load index", {v_we, idx}, {1'b0, idx_model});
            end
            4'hF: begin
                chk(fx_req && !v_we && fx_sel == lo, "R7 second-stage dispatch",
                    {fx_req, v_we, fx_sel}, {2'b10, lo});
            end
            default: begin
                chk(!v_we && !alu_req && !fx_req && idx == idx_model, "R8 no effect",
                    {v_we, alu_req, fx_req, idx}, {3'b000, idx_model});
            end
        endcase
        if (hi[7:4] != 4'hA)
            chk(idx == idx_model, "R6 idx held", idx, idx_model);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) chk(!done, "R2 done single cycle", done, 0);
            if (interfere && done) chk(0, "R10 busy start ignored", done, 0);
        end
        if (interfere) chk(!done && idx == idx_model, "R10 busy start ignored", done, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000C8A5));
        repeat (3) @(negedge clk);
        chk(!done && !pc_adv && !v_we && !alu_req && !fx_req && idx == 12'h000, "R1 reset state",
            {done, pc_adv, v_we, alu_req, fx_req, idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !pc_adv && idx == 12'h000, "R1 after release", {done, pc_adv, idx}, 0);

        run_op(8'h60, 8'h00, 0);
        run_op(8'h6F, 8'hFF, 0);
        run_op(8'h83, 8'hC0, 0);
        run_op(8'h8F, 8'h00, 0);
        run_op(8'h80, 8'hF0, 0);
        for (int n = 1; n < 16; n++) run_op(8'h82, {4'h7, 4'(n)}, 0);
        run_op(8'hAD, 8'h08, 0);
        run_op(8'hAF, 8'hFF, 0);
        run_op(8'hF3, 8'h55, 0);
        run_op(8'hF0, 8'h65, 0);
        run_op(8'h1A, 8'h23, 0);
        run_op(8'hD1, 8'h25, 0);
        run_op(8'hA1, 8'h2C, 1);
        run_op(8'h84, 8'h50, 1);
        run_op(8'hF2, 8'h1E, 1);

        for (int r = 0; r < 80; r++) begin
            logic [7:0] h, l;
            h = 8'($urandom);
            l = 8'($urandom);
            if (r % 3 == 0) h[7:4] = (r % 2 == 0) ? 4'h8 : 4'h6;
            run_op(h, l, ($urandom % 5) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule